// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs one asynchronous access at a time to a NOR- or SRAM-style device that shares a single bus for address and data. At the start of an access it drives the address onto the bus, and an address-valid strobe tells the device to latch it. The bus then turns around. On a read the block releases the bus and pulses output-enable. On a write it drives the data and pulses write-enable. The read data is taken from the bus at a programmed access-time point.

Each chip select has its own configuration word, written through a simple configuration port. The word holds the device kind, the bus-sharing mode and the cycle counts that place every strobe edge and the access point. It also says whether an external wait input can stretch the data phase, which of the two wait pins to use, and which level of that pin means "wait". Requests arrive on a valid/ready port. The block answers each request with a one-cycle done pulse, which carries the read data or an error flag.

Top module: `muxbus_seq`

## Requirements
- R1: During and right after reset, every chip select, address-valid, output-enable and write-enable pin is high (inactive), `ad_oe` is 0, `rsp_done` is 0 and `req_ready` is 1. Reset clears every configuration word to all zeros.
- R2: An access runs only if the target's configuration has device kind 2'b00 (NOR/SRAM style) and bus-sharing mode 2'b10 (multiplexed). For any other value the request ends with `rsp_done` and `rsp_err` high in the cycle after acceptance, and no chip-select or strobe pin moves. A zeroed word is therefore rejected.
- R3: Cycle 0 is the first cycle after the clock edge that accepts the request. In cycles `adv_on` up to `adv_off`-1, `mem_adv_n` is low. In cycles 0 to `adv_off`-1, `ad_oe` is 1 and `ad_out` carries the request address. Only the selected chip select is low for the whole access.
- R4: On a read, `ad_oe` is 0 from cycle `adv_off` on. `mem_oe_n` is low in cycles `oe_on` up to `oe_off`-1. `ad_in` is sampled at the end of cycle `rd_acc`. The configuration must satisfy adv_off <= oe_on <= rd_acc < oe_off.
- R5: On a write, `ad_out` carries the write data with `ad_oe` = 1 from cycle `adv_off` to the end of the access. `mem_we_n` is low in cycles `we_on` up to `we_off`-1. The configuration must satisfy we_on <= wr_acc < we_off.
- R6: The wait pins pass through a two-flop synchronizer. If waiting is enabled and the synchronized selected pin is at its active level in the access-time cycle (`rd_acc` or `wr_acc`), that cycle repeats. The active strobe stays low, and every later edge moves by the number of extra cycles. If the pin is released at the falling clock edge of cycle t (t+2 >= access time), the access stretches by t+2-access time cycles.
- R7: A wait level on the pin that is not selected, or on either pin while waiting is disabled, leaves the access timing unchanged.
- R8: Wait polarity bit 1 makes a high pin level mean wait, and bit 0 makes a low level mean wait.
- R9: `rsp_done` is a one-cycle pulse in the cycle after the active strobe rises (cycle strobe_off+stall+1), with `rsp_rdata` valid for reads. The chip select stays low through that cycle and goes high in the next cycle, when `req_ready` returns to 1.
- R10: `mem_oe_n` and `mem_we_n` are never low together, and `ad_oe` is 0 whenever `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a configuration word |
| cfg_cs | input | CS_W | Chip select whose word is written |
| cfg_data | input | $bits(cs_cfg_t) | Configuration word (package struct) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_cs | input | CS_W | Target chip select |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | BUS_W | Access address |
| req_wdata | input | BUS_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a rejected request |
| rsp_rdata | output | BUS_W | Read data |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| ad_out | output | BUS_W | Shared bus output value |
| ad_oe | output | 1 | Shared bus output-driver enable |
| ad_in | input | BUS_W | Shared bus input value |
| wait_in | input | 2 | The two external wait pins |

## Verification
The bench builds the block with BUS_W = 16 and NUM_CS = 2. This gives two independent configuration words, so one chip select can be set to use wait pin 0 with low polarity while the other uses pin 1 with high polarity. Cross-pin isolation, both polarities and the disable bit can then be exercised in one run. With 16-bit data, the address and write data are distinct values, so the bench can tell address phase from data phase on the bus. Two chip selects also allow a rejected device kind on one target while the other keeps working.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    localparam int TCW       = 4;
    localparam int WAIT_PINS = 2;

    localparam logic [1:0] KIND_NORSRAM = 2'b00;
    localparam logic [1:0] SHARE_AD     = 2'b10;

    typedef logic [TCW-1:0] tick_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic [1:0] dev_kind;
        logic [1:0] share_mode;
        logic       wait_en;
        logic       wait_pin;
        logic       wait_hi;
        tick_t      adv_on;
        tick_t      adv_off;
        tick_t      oe_on;
        tick_t      oe_off;
        tick_t      we_on;
        tick_t      we_off;
        tick_t      rd_acc;
        tick_t      wr_acc;
    } cs_cfg_t;

    function automatic logic cfg_usable(cs_cfg_t c);
        return (c.dev_kind == KIND_NORSRAM) && (c.share_mode == SHARE_AD);
    endfunction

    function automatic logic in_window(tick_t t, tick_t lo, tick_t hi);
        return (t >= lo) && (t < hi);
    endfunction

endpackage

// File: rtl/muxbus_cfg_bank.sv
module muxbus_cfg_bank import muxbus_pkg::*; #(
    parameter int NUM_CS = 2,
    parameter int CS_W   = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CS_W-1:0] wr_cs,
    input  cs_cfg_t         wr_cfg,
    input  logic [CS_W-1:0] rd_cs,
    output cs_cfg_t         rd_cfg
);

    cs_cfg_t cfg_r [NUM_CS];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_r[i] <= '0;
            end else if (wr_en && wr_cs == CS_W'(i)) begin
                cfg_r[i] <= wr_cfg;
            end
        end
    end

    always_comb begin
        rd_cfg = '0;
        for (int k = 0; k < NUM_CS; k++) begin
            if (rd_cs == CS_W'(k)) rd_cfg = cfg_r[k];
        end
    end

endmodule

// File: rtl/muxbus_wait_sync.sv
module muxbus_wait_sync import muxbus_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WAIT_PINS-1:0] pins,
    input  logic                 use_en,
    input  logic                 use_pin,
    input  logic                 use_hi,
    output logic                 wait_act
);

    logic [WAIT_PINS-1:0] meta_q;
    logic [WAIT_PINS-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pins;
            sync_q <= meta_q;
        end
    end

    assign wait_act = use_en && (sync_q[use_pin] == use_hi);

endmodule

// File: rtl/muxbus_seq_fsm.sv
module muxbus_seq_fsm import muxbus_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    start_rnw,
    input  cs_cfg_t start_cfg,
    input  logic    wait_act,
    output seq_st_e st,
    output tick_t   tick,
    output cs_cfg_t cfg_q,
    output logic    rnw_q,
    output logic    err_q,
    output logic    capture
);

    tick_t acc_pt;
    tick_t end_pt;

    assign acc_pt  = rnw_q ? cfg_q.rd_acc : cfg_q.wr_acc;
    assign end_pt  = rnw_q ? cfg_q.oe_off : cfg_q.we_off;
    assign capture = (st == ST_RUN) && (tick == acc_pt) && !wait_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            tick  <= '0;
            cfg_q <= '0;
            rnw_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    cfg_q <= start_cfg;
                    rnw_q <= start_rnw;
                    tick  <= '0;
                    err_q <= !cfg_usable(start_cfg);
                    st    <= cfg_usable(start_cfg) ? ST_RUN : ST_FIN;
                end
                ST_RUN: begin
                    if (tick == end_pt) begin
                        st <= ST_FIN;
                    end else if (!(tick == acc_pt && wait_act)) begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq import muxbus_pkg::*; #(
    parameter int  BUS_W  = 16,
    parameter int  NUM_CS = 2,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int CFG_W  = $bits(cs_cfg_t)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CS_W-1:0]      cfg_cs,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [CS_W-1:0]      req_cs,
    input  logic                 req_rnw,
    input  logic [BUS_W-1:0]     req_addr,
    input  logic [BUS_W-1:0]     req_wdata,
    output logic                 rsp_done,
    output logic                 rsp_err,
    output logic [BUS_W-1:0]     rsp_rdata,
    output logic [NUM_CS-1:0]    mem_cs_n,
    output logic                 mem_adv_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [BUS_W-1:0]     ad_out,
    output logic                 ad_oe,
    input  logic [BUS_W-1:0]     ad_in,
    input  logic [WAIT_PINS-1:0] wait_in
);

    cs_cfg_t         sel_cfg;
    cs_cfg_t         cfg_q;
    seq_st_e         st;
    tick_t           tick;
    logic            rnw_q, err_q, capture, wait_act, start, run, cs_live;
    logic [CS_W-1:0] cs_q;
    logic [BUS_W-1:0] addr_q, wdata_q, rdata_q;

    assign req_ready = (st == ST_IDLE);
    assign start     = req_valid && req_ready;

    muxbus_cfg_bank #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_cs(cfg_cs), .wr_cfg(cs_cfg_t'(cfg_data)),
        .rd_cs(req_cs), .rd_cfg(sel_cfg)
    );

    muxbus_wait_sync u_wait (
        .clk(clk), .rst(rst), .pins(wait_in),
        .use_en(cfg_q.wait_en), .use_pin(cfg_q.wait_pin), .use_hi(cfg_q.wait_hi),
        .wait_act(wait_act)
    );

    muxbus_seq_fsm u_fsm (
        .clk(clk), .rst(rst),
        .start(start), .start_rnw(req_rnw), .start_cfg(sel_cfg),
        .wait_act(wait_act),
        .st(st), .tick(tick), .cfg_q(cfg_q), .rnw_q(rnw_q),
        .err_q(err_q), .capture(capture)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                cs_q    <= req_cs;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture && rnw_q) rdata_q <= ad_in;
        end
    end

    assign run     = (st == ST_RUN);
    assign cs_live = run || ((st == ST_FIN) && !err_q);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign mem_cs_n[i] = !(cs_live && cs_q == CS_W'(i));
    end

    assign mem_adv_n = !(run && in_window(tick, cfg_q.adv_on, cfg_q.adv_off));
    assign mem_oe_n  = !(run && rnw_q && in_window(tick, cfg_q.oe_on, cfg_q.oe_off));
    assign mem_we_n  = !(run && !rnw_q && in_window(tick, cfg_q.we_on, cfg_q.we_off));
    assign ad_oe     = run && ((tick < cfg_q.adv_off) || !rnw_q);
    assign ad_out    = (tick < cfg_q.adv_off) ? addr_q : wdata_q;

    assign rsp_done  = (st == ST_FIN);
    assign rsp_err   = (st == ST_FIN) && err_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/muxbus_seq_chk.sv
module muxbus_seq_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              mem_adv_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              ad_oe
);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_cs_release_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (&mem_cs_n));

    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    p_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !(&mem_cs_n) |-> !req_ready);

    p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_adv_n || !mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

    p_no_contention_r10: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !ad_oe);

    p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!mem_oe_n, !mem_we_n}));

    p_err_silent_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_done && (&mem_cs_n) && mem_adv_n));

endmodule

bind muxbus_seq muxbus_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .ad_oe(ad_oe)
);

// File: tb/sim_muxbus_seq.sv
`timescale 1ns/1ps
module sim_muxbus_seq;
    import muxbus_pkg::*;

    localparam int BW = 16;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_cs = '0;
    cs_cfg_t       cfg_data = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [0:0]    req_cs = '0;
    logic          req_rnw = 1'b0;
    logic [BW-1:0] req_addr = '0, req_wdata = '0;
    logic          rsp_done, rsp_err;
    logic [BW-1:0] rsp_rdata;
    logic [NC-1:0] mem_cs_n;
    logic          mem_adv_n, mem_oe_n, mem_we_n, ad_oe;
    logic [BW-1:0] ad_out, ad_in;
    logic [1:0]    wait_in = 2'b00;
    logic [BW-1:0] dev_data = '0;

    always #2 clk = ~clk;

    assign ad_in = mem_oe_n ? '0 : dev_data;

    muxbus_seq #(.BUS_W(BW), .NUM_CS(NC)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
        .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .wait_in(wait_in)
    );

    typedef struct {
        int            cs;
        bit            rnw;
        logic [BW-1:0] addr;
        logic [BW-1:0] wdata;
        logic [BW-1:0] rdata;
        bit            err;
        int            stall;
        cs_cfg_t       c;
    } exp_t;

    exp_t    sb_q[$];
    cs_cfg_t shadow [NC];
    int      n_chk = 0, n_fail = 0, n_cyc = 0;
    bit      finished = 1'b0;

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic cs_cfg_t mk(int ao, int af, int oo, int of, int wo, int wf,
                                   int ra, int wa, bit we, bit wp, bit wh);
        cs_cfg_t c;
        c.dev_kind = 2'b00; c.share_mode = 2'b10;
        c.wait_en = we; c.wait_pin = wp; c.wait_hi = wh;
        c.adv_on = tick_t'(ao); c.adv_off = tick_t'(af);
        c.oe_on = tick_t'(oo);  c.oe_off = tick_t'(of);
        c.we_on = tick_t'(wo);  c.we_off = tick_t'(wf);
        c.rd_acc = tick_t'(ra); c.wr_acc = tick_t'(wa);
        return c;
    endfunction

    task automatic write_cfg(int cs, cs_cfg_t c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cs = 1'(cs); cfg_data = c;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[cs] = c;
    endtask

    // driver: pushes expected item, issues request, releases wait at cycle rel
    task automatic access(int cs, bit rnw, logic [BW-1:0] a, logic [BW-1:0] w,
                          logic [BW-1:0] d, int rel, logic [1:0] relv, int stall);
        exp_t e;
        e.cs = cs; e.rnw = rnw; e.addr = a; e.wdata = w; e.rdata = d;
        e.c = shadow[cs]; e.stall = stall;
        e.err = !cfg_usable(shadow[cs]);
        sb_q.push_back(e);
        repeat (3) @(negedge clk);
        dev_data = d;
        req_valid = 1'b1; req_cs = 1'(cs); req_rnw = rnw; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 64; k++) begin
            if (k == rel) wait_in = relv;
            if (rsp_done) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk((&mem_cs_n) && req_ready, "R9 chip select high and ready after done",
            {mem_cs_n, req_ready}, {NC{1'b1}} << 1 | 1);
    endtask

    // monitor: per-cycle pin checks and completion compare
    int mon_n = 0;
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            int acc, off, t;
            bit eadv, eoe, ewe, ebus;
            e = sb_q[0];
            acc = e.rnw ? int'(e.c.rd_acc) : int'(e.c.wr_acc);
            off = e.rnw ? int'(e.c.oe_off) : int'(e.c.we_off);
            if (e.err) begin
                if (rsp_done) begin
                    chk(rsp_err && (&mem_cs_n), "R2 rejected access error, no chip select",
                        {rsp_err, mem_cs_n}, {1'b1, {NC{1'b1}}});
                    void'(sb_q.pop_front());
                end else begin
                    chk((&mem_cs_n) && mem_adv_n, "R2 pins idle for rejected access",
                        {mem_cs_n, mem_adv_n}, {{NC{1'b1}}, 1'b1});
                end
            end else if (mem_cs_n[e.cs] == 1'b0) begin
                if (rsp_done) begin
                    chk(mon_n == off + e.stall + 1, "R9 R6 done cycle", 64'(mon_n),
                        64'(off + e.stall + 1));
                    chk(!rsp_err, "R9 no error", 64'(rsp_err), 0);
                    if (e.rnw)
                        chk(rsp_rdata == e.rdata, "R4 read data", rsp_rdata, e.rdata);
                    void'(sb_q.pop_front());
                    mon_n = 0;
                end else begin
                    if (mon_n <= acc) t = mon_n;
                    else if (mon_n <= acc + e.stall) t = acc;
                    else t = mon_n - e.stall;
                    eadv = (t >= int'(e.c.adv_on)) && (t < int'(e.c.adv_off));
                    eoe  = e.rnw && (t >= int'(e.c.oe_on)) && (t < int'(e.c.oe_off));
                    ewe  = !e.rnw && (t >= int'(e.c.we_on)) && (t < int'(e.c.we_off));
                    ebus = (t < int'(e.c.adv_off)) || !e.rnw;
                    chk(mon_n <= off + e.stall, "R9 access overran", 64'(mon_n),
                        64'(off + e.stall));
                    chk({mem_adv_n, mem_oe_n, mem_we_n, ad_oe} == {!eadv, !eoe, !ewe, ebus},
                        "R3 R4 R5 R6 R7 R8 strobes and bus enable",
                        {mem_adv_n, mem_oe_n, mem_we_n, ad_oe}, {!eadv, !eoe, !ewe, ebus});
                    if (ebus)
                        chk(ad_out == ((t < int'(e.c.adv_off)) ? e.addr : e.wdata),
                            "R3 R5 bus value", ad_out,
                            (t < int'(e.c.adv_off)) ? e.addr : e.wdata);
                    chk(mem_oe_n || mem_we_n, "R10 strobes exclusive",
                        {mem_oe_n, mem_we_n}, 2'b11);
                    mon_n++;
                end
            end
        end
    end

    function automatic int stall_of(int rel, int acc);
        return (rel + 2 - acc > 0) ? rel + 2 - acc : 0;
    endfunction

    initial begin
        cs_cfg_t ca, cb, bad;
        shadow[0] = '0; shadow[1] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk((&mem_cs_n) && mem_adv_n && mem_oe_n && mem_we_n && !ad_oe && !rsp_done && req_ready,
            "R1 reset state", {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, ad_oe, rsp_done, req_ready},
            {{NC{1'b1}}, 5'b11100, 1'b1});
        rst = 1'b0;
        @(negedge clk);
        chk((&mem_cs_n) && req_ready && !rsp_done, "R1 idle after reset",
            {mem_cs_n, req_ready, rsp_done}, {{NC{1'b1}}, 2'b10});

        // R2: zeroed configuration rejects
        access(0, 1'b1, 16'h1234, 16'h0, 16'h0, -1, 2'b00, 0);

        ca = mk(1, 3, 4, 8, 4, 7, 6, 5, 1'b0, 1'b0, 1'b0);
        cb = mk(0, 2, 2, 6, 3, 6, 4, 4, 1'b1, 1'b1, 1'b1);
        write_cfg(0, ca);
        // R3 R4 plain read, R5 plain write
        access(0, 1'b1, 16'hA5C3, 16'h0, 16'h5E71, -1, 2'b00, 0);
        access(0, 1'b0, 16'h0F0F, 16'hBEEF, 16'h0, -1, 2'b00, 0);

        // R2: wrong device kind on cs1
        bad = cb; bad.dev_kind = 2'b01;
        write_cfg(1, bad);
        access(1, 1'b1, 16'h2222, 16'h0, 16'h0, -1, 2'b00, 0);
        bad = cb; bad.share_mode = 2'b00;
        write_cfg(1, bad);
        access(1, 1'b0, 16'h2223, 16'h1, 16'h0, -1, 2'b00, 0);

        // R6 R8 wait on pin 1, high active, read stretched
        write_cfg(1, cb);
        wait_in = 2'b10;
        access(1, 1'b1, 16'h3001, 16'h0, 16'hC0DE, 6, 2'b00, stall_of(6, 4));
        // R6 write stretched by exactly one cycle
        wait_in = 2'b10;
        access(1, 1'b0, 16'h3002, 16'h7777, 16'h0, 3, 2'b00, stall_of(3, 4));
        // R7 unselected pin 0 active, selected pin quiet
        wait_in = 2'b01;
        access(1, 1'b1, 16'h3003, 16'h0, 16'h1357, -1, 2'b01, 0);
        // R7 waiting disabled while both pins high
        cb.wait_en = 1'b0;
        write_cfg(1, cb);
        wait_in = 2'b11;
        access(1, 1'b1, 16'h3004, 16'h0, 16'h2468, -1, 2'b11, 0);

        // R8 low-active polarity on pin 0
        ca.wait_en = 1'b1; ca.wait_pin = 1'b0; ca.wait_hi = 1'b0;
        write_cfg(0, ca);
        wait_in = 2'b10;
        access(0, 1'b1, 16'h4001, 16'h0, 16'h9ABC, 5, 2'b11, stall_of(5, 6));
        // R8 pin 0 high is not a wait for low polarity
        wait_in = 2'b01;
        access(0, 1'b0, 16'h4002, 16'hFACE, 16'h0, -1, 2'b01, 0);

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R9 every request completed", 64'(sb_q.size()), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 20000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", n_cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule